// File: doc/BRIEF.md
# Twelve-Hour BCD Time-of-Day Counter

This block keeps wall-clock time in binary-coded decimal. It advances one second each time a one-cycle tick strobe is present on the system clock. It is meant to sit beside a divider that produces the once-per-second strobe. Its digit outputs feed a display path or a comparator directly.

Seconds and minutes are each a pair of decimal digits that run from 00 to 59. Hours use a units digit plus a single tens bit. The hour runs 1 through 12 and then returns to 1, never to 0. Each of the three stages raises a carry strobe in the same cycle in which it is about to roll over, so the next stage steps on that same clock edge. Every update, wrap and reload is synchronous to the one clock. After reset the counter shows 12:00:00.

Top module: `clk12_chain`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is 12:00:00: `hr_tens`=1, `hr_units`=2, and all minute and second digits are 0. With `tick` low, all three carries are low.
- R2: On each rising edge with `tick` high, the seconds units digit moves up by one, staying within 0 to 9. The seconds tens digit changes only on the edge where the units digit goes from 9 to 0.
- R3: `sec_carry` is high exactly when `tick` is high and the seconds read 59. On that edge the seconds become 00.
- R4: The minutes go up by one only on an edge where `sec_carry` is high. `min_carry` is high exactly when `sec_carry` is high and the minutes read 59. On that edge the minutes become 00.
- R5: On an edge where `min_carry` is high, hour 9 becomes 10 (`hr_tens`=1, `hr_units`=0). Hours 10 and 11 step to 11 and 12.
- R6: `hr_carry` is high exactly when `min_carry` is high and the hour reads 12. On that edge the hour becomes 01 (`hr_tens`=0, `hr_units`=1).
- R7: On an edge with `tick` low, no digit changes and all carries are low.
- R8: The hour is always within 1 to 12. `hr_units` is never 0 while `hr_tens` is 0, and never above 2 while `hr_tens` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, loads 12:00:00 |
| tick | input | 1 | One-cycle strobe that advances time by one second |
| sec_units | output | 4 | Seconds units digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD 0 to 5 |
| min_units | output | 4 | Minutes units digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD 0 to 5 |
| hr_units | output | 4 | Hours units digit, BCD |
| hr_tens | output | 1 | Hours tens bit (hour is 10 to 12 when set) |
| sec_carry | output | 1 | Seconds stage rolls 59 to 00 on this edge |
| min_carry | output | 1 | Minutes stage rolls 59 to 00 on this edge |
| hr_carry | output | 1 | Hours stage reloads 12 to 01 on this edge |

## Verification
The assertions check several properties on every cycle. They check the digit ranges and the legal hour encoding. They check that all digits hold when the tick is absent. They check that the seconds units digit steps by one on each tick. They also check that every carry strobe is followed by the matching 00 or 01 state on the next edge. Only the bench's scenarios show the full sequence. That sequence covers hour 9 becoming 10, the value of each carry against a reference time, and an entire twelve-hour cycle returning to its start. The bench runs this with both sparse and back-to-back ticks.

// File: rtl/clk12_pkg.sv
package clk12_pkg;

    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] bcd_t;

    typedef struct packed {
        bcd_t tens;
        bcd_t units;
    } pair_t;

    typedef struct packed {
        logic tens;
        bcd_t units;
    } hour_t;

    localparam bcd_t DEC_LAST    = 4'd9;
    localparam bcd_t SEXT_LAST   = 4'd5;
    localparam bcd_t ZERO_DIGIT  = 4'd0;
    localparam bcd_t HR_TOP_UNIT = 4'd2;
    localparam bcd_t HR_RELOAD   = 4'd1;

    function automatic bcd_t bcd_next(bcd_t v, bcd_t last, bcd_t first);
        return (v == last) ? first : v + 4'd1;
    endfunction

endpackage

// File: rtl/bcd_digit.sv
module bcd_digit
    import clk12_pkg::*;
#(
    parameter bcd_t LAST  = DEC_LAST,
    parameter bcd_t FIRST = ZERO_DIGIT,
    parameter bcd_t INIT  = ZERO_DIGIT
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output bcd_t q,
    output logic at_last
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= INIT;
        else if (en)
            q <= bcd_next(q, LAST, FIRST);
    end

    assign at_last = (q == LAST);

endmodule

// File: rtl/sixty_stage.sv
module sixty_stage
    import clk12_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    output pair_t val,
    output logic  carry
);

    localparam int NDIG = 2;

    logic [NDIG-1:0] dig_en;
    logic [NDIG-1:0] dig_last;
    bcd_t            dig_q [NDIG];

    generate
        for (genvar i = 0; i < NDIG; i++) begin : g_dig
            localparam bcd_t LIM = (i == 0) ? DEC_LAST : SEXT_LAST;
            if (i == 0) begin : g_first
                assign dig_en[i] = en;
            end else begin : g_next
                assign dig_en[i] = dig_en[i-1] & dig_last[i-1];
            end
            bcd_digit #(
                .LAST (LIM),
                .FIRST(ZERO_DIGIT),
                .INIT (ZERO_DIGIT)
            ) u_digit (
                .clk    (clk),
                .rst    (rst),
                .en     (dig_en[i]),
                .q      (dig_q[i]),
                .at_last(dig_last[i])
            );
        end
    endgenerate

    assign val.units = dig_q[0];
    assign val.tens  = dig_q[1];
    assign carry     = dig_en[NDIG-1] & dig_last[NDIG-1];

endmodule

// File: rtl/hour_stage.sv
module hour_stage
    import clk12_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    output hour_t val,
    output logic  carry
);

    hour_t cur, nxt;
    logic  at_top;

    assign at_top = cur.tens && (cur.units == HR_TOP_UNIT);

    always_comb begin
        nxt = cur;
        if (at_top) begin
            nxt.tens  = 1'b0;
            nxt.units = HR_RELOAD;
        end else if (cur.units == DEC_LAST) begin
            nxt.tens  = 1'b1;
            nxt.units = ZERO_DIGIT;
        end else begin
            nxt.units = cur.units + 4'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.tens  <= 1'b1;
            cur.units <= HR_TOP_UNIT;
        end else if (en) begin
            cur <= nxt;
        end
    end

    assign val   = cur;
    assign carry = en & at_top;

endmodule

// File: rtl/clk12_chain.sv
module clk12_chain
    import clk12_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    output logic [3:0] sec_units,
    output logic [3:0] sec_tens,
    output logic [3:0] min_units,
    output logic [3:0] min_tens,
    output logic [3:0] hr_units,
    output logic       hr_tens,
    output logic       sec_carry,
    output logic       min_carry,
    output logic       hr_carry
);

    pair_t sec_v, min_v;
    hour_t hr_v;

    sixty_stage u_sec (
        .clk  (clk),
        .rst  (rst),
        .en   (tick),
        .val  (sec_v),
        .carry(sec_carry)
    );

    sixty_stage u_min (
        .clk  (clk),
        .rst  (rst),
        .en   (sec_carry),
        .val  (min_v),
        .carry(min_carry)
    );

    hour_stage u_hr (
        .clk  (clk),
        .rst  (rst),
        .en   (min_carry),
        .val  (hr_v),
        .carry(hr_carry)
    );

    assign sec_units = sec_v.units;
    assign sec_tens  = sec_v.tens;
    assign min_units = min_v.units;
    assign min_tens  = min_v.tens;
    assign hr_units  = hr_v.units;
    assign hr_tens   = hr_v.tens;

endmodule

// File: rtl/clk12_chain_chk.sv
module clk12_chain_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic [3:0] sec_units,
    input logic [3:0] sec_tens,
    input logic [3:0] min_units,
    input logic [3:0] min_tens,
    input logic [3:0] hr_units,
    input logic       hr_tens,
    input logic       sec_carry,
    input logic       min_carry,
    input logic       hr_carry
);

    AST_RESET_NOON: assert property (@(posedge clk)
        rst |=> (hr_tens && hr_units == 4'd2 && min_tens == 4'd0 && min_units == 4'd0
                 && sec_tens == 4'd0 && sec_units == 4'd0)); // R1

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && sec_units != 4'd9) |=> (sec_units == $past(sec_units) + 4'd1)); // R2

    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        (sec_units <= 4'd9 && sec_tens <= 4'd5)); // R2

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        sec_carry |=> (sec_units == 4'd0 && sec_tens == 4'd0)); // R3

    AST_MIN_WRAP: assert property (@(posedge clk) disable iff (rst)
        min_carry |=> (min_units == 4'd0 && min_tens == 4'd0)); // R4

    AST_MIN_ONLY_ON_CARRY: assert property (@(posedge clk) disable iff (rst)
        !sec_carry |=> ($stable(min_units) && $stable(min_tens))); // R4

    AST_HR_RELOAD: assert property (@(posedge clk) disable iff (rst)
        hr_carry |=> (!hr_tens && hr_units == 4'd1)); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(sec_units) && $stable(sec_tens) && $stable(min_units)
                   && $stable(min_tens) && $stable(hr_units) && $stable(hr_tens))); // R7

    AST_IDLE_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        !tick |-> !(sec_carry || min_carry || hr_carry)); // R7

    AST_HOUR_LEGAL: assert property (@(posedge clk) disable iff (rst)
        hr_tens ? (hr_units <= 4'd2) : (hr_units != 4'd0 && hr_units <= 4'd9)); // R8

endmodule

bind clk12_chain clk12_chain_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .sec_units(sec_units),
    .sec_tens (sec_tens),
    .min_units(min_units),
    .min_tens (min_tens),
    .hr_units (hr_units),
    .hr_tens  (hr_tens),
    .sec_carry(sec_carry),
    .min_carry(min_carry),
    .hr_carry (hr_carry)
);

// File: tb/tb_clk12_chain.sv
module tb_clk12_chain;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [3:0] sec_units, sec_tens, min_units, min_tens, hr_units;
    logic       hr_tens, sec_carry, min_carry, hr_carry;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int h = 12, m = 0, s = 0;

    typedef struct {
        int    eh;
        int    em;
        int    es;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    clk12_chain dut (
        .clk(clk), .rst(rst), .tick(tick),
        .sec_units(sec_units), .sec_tens(sec_tens),
        .min_units(min_units), .min_tens(min_tens),
        .hr_units(hr_units), .hr_tens(hr_tens),
        .sec_carry(sec_carry), .min_carry(min_carry), .hr_carry(hr_carry)
    );

    task automatic check_int(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int dut_hour();
        return (hr_tens ? 10 : 0) + int'(hr_units);
    endfunction

    task automatic check_time(string tag, int eh, int em, int es);
        check_int(tag, "hour",   dut_hour(), eh);
        check_int(tag, "minute", int'(min_tens) * 10 + int'(min_units), em);
        check_int(tag, "second", int'(sec_tens) * 10 + int'(sec_units), es);
    endtask

    // driver: drives tick at the falling edge, checks the carries and
    // queues the expected post-edge time
    task automatic drive(bit t);
        exp_t  e;
        bit    sc, mc, hc;
        string tag;
        @(negedge clk);
        tick = t;
        #1;
        sc = t && (s == 59);
        mc = sc && (m == 59);
        hc = mc && (h == 12);
        tag = !t ? "R7" : hc ? "R6" : mc ? "R4" : sc ? "R3" : "R2";
        check_int(tag, "sec_carry", int'(sec_carry), int'(sc));
        check_int(tag, "min_carry", int'(min_carry), int'(mc));
        check_int(tag, "hr_carry",  int'(hr_carry),  int'(hc));
        if (t) begin
            if (hc)            h = 1;
            else if (mc)       h = h + 1;
            if (mc)            m = 0;
            else if (sc)       m = m + 1;
            s = sc ? 0 : s + 1;
        end
        if (!t) tag = "R7";
        else if (hc) tag = "R6";
        else if (mc && h == 10) tag = "R5";
        e.eh = h; e.em = m; e.es = s; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: after each rising edge, compare against the queue head
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check_time(e.tag, e.eh, e.em, e.es);
                checks++;
                if (hr_tens ? (hr_units > 4'd2) : (hr_units == 4'd0 || hr_units > 4'd9)) begin
                    fails++;
                    $display("FAIL R8 hour encoding: actual tens=%0d units=%0d expected 1..12",
                             hr_tens, hr_units);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 190000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check_time("R1", 12, 0, 0);
        check_int("R1", "sec_carry", int'(sec_carry), 0);
        check_int("R1", "min_carry", int'(min_carry), 0);
        check_int("R1", "hr_carry",  int'(hr_carry),  0);

        // R7 idle cycles hold
        for (int i = 0; i < 5; i++) drive(0);
        // R2 sparse ticks
        for (int i = 0; i < 30; i++) begin
            drive(1);
            drive(0);
            drive(0);
        end
        // continuous ticks through a full twelve-hour cycle and beyond
        for (int i = 0; i < 43200 + 4000; i++) drive(1);
        // R7 hold after long run
        for (int i = 0; i < 4; i++) drive(0);

        // reset mid-run returns to 12:00:00
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #3;
        sb.delete();
        h = 12; m = 0; s = 0;
        check_time("R1", 12, 0, 0);
        for (int i = 0; i < 70; i++) drive(1);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule